// File: doc/BRIEF.md
# ADC DMA Instruction Sequencer

This block stores ADC conversion results in a byte-wide data memory under the control of a small program. The program sits in a 64-entry instruction buffer that holds one byte per entry. Each instruction names the converter results to capture: the single-ended ADC0 result, the differential ADC0 result, the ADC1 result, or any mix of the three. The sequencer waits until every converter the instruction needs reports valid data. It then acknowledges the conversion and writes each captured 16-bit result to memory, high byte first, at consecutive addresses.

A repeat count makes each instruction run several times before the instruction pointer moves on. An End-of-Operation instruction sends the pointer back to a boundary address. A flag in that instruction decides whether execution keeps looping or stops. When execution stops, the block drops busy and raises a one-cycle completion pulse.

The instruction buffer is loaded through a simple byte write port. The converters are modelled as valid/data inputs that share one acknowledge output.

Top module: `adc_seq_dma`

## Requirements
- R1: While reset is high and in the cycle after it is released, busy, done, adc_ack and mem_we are all 0.
- R2: A start pulse while idle makes busy go high in the next cycle, and execution begins with the buffer entry at bnd_addr. A start pulse while busy has no effect on the handshakes or the memory writes.
- R3: adc_ack is high for one cycle, and only when every converter the current instruction selects has its valid input high. The data captured is the value on the data inputs in that cycle. ADC0 and differential ADC0 both use adc0_valid.
- R4: Instruction encoding: bit 0 = 1 marks End-of-Operation. Otherwise bit 4 selects ADC0, bit 6 selects differential ADC0 and bit 5 selects ADC1, and bits 7 and 3..1 are ignored. Results are stored in the order ADC0, differential ADC0, ADC1, each as the high byte then the low byte.
- R5: A capture or no-op instruction runs max(L,1) times, where L is rpt_limit. The pointer then advances by one and the repeat counter reloads from rpt_limit.
- R6: Advancing past entry 0x3F continues at entry 0x00.
- R7: An End-of-Operation instruction with bit 7 = 0 halts execution. Busy falls and done is high for exactly one cycle, in the same cycle. No further writes or handshakes follow.
- R8: An End-of-Operation instruction with bit 7 = 1 restarts execution at bnd_addr with busy held high. The write address is not reloaded and keeps counting.
- R9: The write address is loaded from wr_base on start and rises by one after every byte written.
- R10: An instruction with none of bits 4..6 set and bit 0 = 0 completes without a handshake and without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation cycle when idle |
| bnd_addr | input | 6 | Boundary (start and wrap) instruction address |
| rpt_limit | input | 16 | Repeat count reload value |
| wr_base | input | 16 | First data memory address of an operation cycle |
| prog_we | input | 1 | Instruction buffer write strobe |
| prog_addr | input | 6 | Instruction buffer write address |
| prog_data | input | 8 | Instruction byte to write |
| adc0_valid | input | 1 | ADC0 result available (single-ended and differential) |
| adc0_data | input | 16 | ADC0 single-ended result |
| adc0_diff_data | input | 16 | ADC0 differential result |
| adc1_valid | input | 1 | ADC1 result available |
| adc1_data | input | 16 | ADC1 result |
| adc_ack | output | 1 | Conversion data taken this cycle |
| mem_we | output | 1 | Data memory byte write strobe |
| mem_addr | output | 16 | Data memory byte address |
| mem_wdata | output | 8 | Data memory byte |
| busy | output | 1 | Instructions executing |
| done | output | 1 | One-cycle pulse when execution halts |

## Verification
adc_ack is combinational from the valid inputs in the waiting state. The bench drives the valid inputs at the falling edge, waits one time unit and reads adc_ack in the same cycle. The first byte write follows one cycle after the capturing edge, and the rest of that instruction's bytes follow on consecutive cycles. The bench therefore compares each write at the falling edge in which mem_we is high, against a queue of expected bytes and an expected address counter, rather than at fixed offsets. Done rises two cycles after the last write of a halting program: one fetch cycle, then the halt edge. It is checked at the falling edge it appears and again one cycle later to confirm it lasts a single cycle.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int RES_W   = 16;
    localparam int INSTR_W = 8;
    localparam int BYTE_W  = 8;
    localparam int NSLOT   = 3;   // storage order: ADC0, differential ADC0, ADC1

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_WRITE
    } seq_state_e;

    typedef logic [NSLOT-1:0] slot_mask_t;

    typedef struct packed {
        logic       eoo;    // end of operation
        logic       cont;   // keep looping after end of operation
        slot_mask_t sel;    // capture mask, bit i = slot i
    } instr_dec_t;

    function automatic instr_dec_t decode_instr(input logic [INSTR_W-1:0] w);
        instr_dec_t d;
        d.eoo  = w[0];
        d.cont = w[7];
        d.sel  = w[0] ? slot_mask_t'(0) : {w[5], w[6], w[4]};
        return d;
    endfunction

    function automatic slot_mask_t lowest_bit(input slot_mask_t m);
        return m & slot_mask_t'(~m + slot_mask_t'(1));
    endfunction

    function automatic logic sel_ready(input slot_mask_t sel,
                                       input logic v0, input logic v1);
        return (!sel[0] || v0) && (!sel[1] || v0) && (!sel[2] || v1);
    endfunction

endpackage

// File: rtl/adcseq_ibuf.sv
module adcseq_ibuf
    import adcseq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [PTR_W-1:0]   waddr,
    input  logic [INSTR_W-1:0] wdata,
    input  logic [PTR_W-1:0]   raddr,
    output logic [INSTR_W-1:0] rdata
);

    logic [INSTR_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/adcseq_iptr.sv
module adcseq_iptr #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,      // start of an operation cycle
    input  logic             wrap,      // end-of-operation seen
    input  logic             complete,  // instruction finished one run
    input  logic [PTR_W-1:0] bnd,
    input  logic [CNT_W-1:0] limit,
    output logic [PTR_W-1:0] ptr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic last_run;
    logic [PTR_W-1:0] ptr_inc;

    assign last_run = (cnt <= CNT_W'(1));
    assign ptr_inc  = (ptr == LAST_PTR) ? '0 : ptr + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            cnt <= '0;
        end else if (load) begin
            ptr <= bnd;
            cnt <= limit;
        end else if (wrap) begin
            ptr <= bnd;
        end else if (complete) begin
            if (last_run) begin
                cnt <= limit;
                ptr <= ptr_inc;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/adcseq_wrseq.sv
module adcseq_wrseq
    import adcseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        base_load,
    input  logic [ADDR_W-1:0]           base,
    input  logic                        capture,
    input  slot_mask_t                  sel,
    input  logic [NSLOT-1:0][RES_W-1:0] res_in,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [BYTE_W-1:0]           mem_wdata,
    output logic                        last
);

    logic [NSLOT-1:0][RES_W-1:0] slot_q;
    slot_mask_t                  pend_q;
    slot_mask_t                  cur;
    logic                        lo_q;
    logic [ADDR_W-1:0]           waddr_q;
    logic [RES_W-1:0]            cur_word;

    assign cur = lowest_bit(pend_q);

    always_comb begin
        cur_word = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (cur[i]) cur_word = slot_q[i];
        end
    end

    assign mem_we    = |pend_q;
    assign mem_addr  = waddr_q;
    assign mem_wdata = lo_q ? cur_word[BYTE_W-1:0] : cur_word[RES_W-1:BYTE_W];
    assign last      = mem_we && lo_q && ((pend_q & ~cur) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            pend_q  <= '0;
            lo_q    <= 1'b0;
            waddr_q <= '0;
        end else begin
            if (base_load) begin
                waddr_q <= base;
            end else if (mem_we) begin
                waddr_q <= waddr_q + ADDR_W'(1);
            end

            if (capture) begin
                slot_q <= res_in;
                pend_q <= sel;
                lo_q   <= 1'b0;
            end else if (mem_we) begin
                lo_q <= !lo_q;
                if (lo_q) pend_q <= pend_q & ~cur;
            end
        end
    end

endmodule

// File: rtl/adc_seq_dma.sv
module adc_seq_dma
    import adcseq_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [PTR_W-1:0]   bnd_addr,
    input  logic [CNT_W-1:0]   rpt_limit,
    input  logic [ADDR_W-1:0]  wr_base,
    input  logic               prog_we,
    input  logic [PTR_W-1:0]   prog_addr,
    input  logic [INSTR_W-1:0] prog_data,
    input  logic               adc0_valid,
    input  logic [RES_W-1:0]   adc0_data,
    input  logic [RES_W-1:0]   adc0_diff_data,
    input  logic               adc1_valid,
    input  logic [RES_W-1:0]   adc1_data,
    output logic               adc_ack,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0]  mem_wdata,
    output logic               busy,
    output logic               done
);

    seq_state_e         state;
    slot_mask_t         cur_sel;
    logic [INSTR_W-1:0] ibuf_rd;
    instr_dec_t         dec;
    logic [PTR_W-1:0]   ptr;
    logic [CNT_W-1:0]   cnt;
    logic               load, wrap, complete, wr_last;
    logic [NSLOT-1:0][RES_W-1:0] res_in;

    assign dec      = decode_instr(ibuf_rd);
    assign load     = (state == ST_IDLE) && start;
    assign wrap     = (state == ST_FETCH) && dec.eoo;
    assign complete = ((state == ST_FETCH) && !dec.eoo && (dec.sel == '0))
                   || ((state == ST_WRITE) && wr_last);
    assign adc_ack  = (state == ST_WAIT) && sel_ready(cur_sel, adc0_valid, adc1_valid);
    assign busy     = (state != ST_IDLE);
    assign res_in   = {adc1_data, adc0_diff_data, adc0_data};

    adcseq_ibuf #(.DEPTH(DEPTH)) u_ibuf (
        .clk   (clk),
        .rst   (rst),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (ptr),
        .rdata (ibuf_rd)
    );

    adcseq_iptr #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_iptr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .wrap     (wrap),
        .complete (complete),
        .bnd      (bnd_addr),
        .limit    (rpt_limit),
        .ptr      (ptr),
        .cnt      (cnt)
    );

    adcseq_wrseq #(.ADDR_W(ADDR_W)) u_wrseq (
        .clk       (clk),
        .rst       (rst),
        .base_load (load),
        .base      (wr_base),
        .capture   (adc_ack),
        .sel       (cur_sel),
        .res_in    (res_in),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .last      (wr_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur_sel <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) state <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (dec.eoo) begin
                        if (!dec.cont) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end else if (dec.sel != '0) begin
                        cur_sel <= dec.sel;
                        state   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (adc_ack) state <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (wr_last) state <= ST_FETCH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adcseq_dma_chk.sv
module adcseq_dma_chk
    import adcseq_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              adc_ack,
    input logic              adc0_valid,
    input logic              adc1_valid,
    input slot_mask_t        cur_sel,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              complete,
    input logic [PTR_W-1:0]  ptr,
    input logic [CNT_W-1:0]  cnt
);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_ack_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
        adc_ack |-> ((!cur_sel[0] || adc0_valid) && (!cur_sel[1] || adc0_valid)
                     && (!cur_sel[2] || adc1_valid)));

    p_ack_single_r3: assert property (@(posedge clk) disable iff (rst)
        adc_ack |=> !adc_ack);

    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !complete) |=> $stable(cnt));

    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (complete && (cnt <= CNT_W'(1)) && (ptr == PTR_W'(DEPTH - 1))) |=> (ptr == '0));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_quiet_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !adc_ack));

    p_addr_step_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

bind adc_seq_dma adcseq_dma_chk #(
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .adc_ack    (adc_ack),
    .adc0_valid (adc0_valid),
    .adc1_valid (adc1_valid),
    .cur_sel    (cur_sel),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .complete   (complete),
    .ptr        (ptr),
    .cnt        (cnt)
);

// File: tb/adc_seq_dma_test.sv
module adc_seq_dma_test;

    localparam int DEPTH  = 64;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 16;
    localparam int PTR_W  = 6;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [PTR_W-1:0]  bnd_addr;
    logic [CNT_W-1:0]  rpt_limit;
    logic [ADDR_W-1:0] wr_base;
    logic              prog_we;
    logic [PTR_W-1:0]  prog_addr;
    logic [7:0]        prog_data;
    logic              adc0_valid, adc1_valid;
    logic [15:0]       adc0_data, adc0_diff_data, adc1_data;
    logic              adc_ack, mem_we, busy, done;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;

    adc_seq_dma #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .start(start), .bnd_addr(bnd_addr),
        .rpt_limit(rpt_limit), .wr_base(wr_base), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .adc0_valid(adc0_valid), .adc0_data(adc0_data),
        .adc0_diff_data(adc0_diff_data), .adc1_valid(adc1_valid),
        .adc1_data(adc1_data), .adc_ack(adc_ack), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int failures = 0;
    logic [7:0]        prog [DEPTH];
    logic [2:0]        exp_sel [$];
    logic [7:0]        exp_bytes [$];
    logic [ADDR_W-1:0] exp_addr;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Expected handshake masks in execution order, built from the requirements.
    function automatic void model(input int bnd, input int lim, input int max_n);
        int p = bnd;
        int runs = (lim <= 1) ? 1 : lim;
        exp_sel.delete();
        for (int step = 0; step < 4000; step++) begin
            logic [7:0] w;
            w = prog[p];
            if (w[0]) begin
                if (!w[7]) return;
                p = bnd;
            end else begin
                for (int r = 0; r < runs; r++) begin
                    if (w[6:4] != 3'b000 && exp_sel.size() < max_n)
                        exp_sel.push_back({w[5], w[6], w[4]});
                end
                p = (p + 1) % DEPTH;
            end
            if (exp_sel.size() >= max_n) return;
        end
    endfunction

    task automatic load_program();
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            prog_we   = 1'b1;
            prog_addr = PTR_W'(a);
            prog_data = prog[a];
        end
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic clear_program();
        for (int a = 0; a < DEPTH; a++) prog[a] = 8'h00;
    endtask

    task automatic run(input int bnd, input int lim, input logic [15:0] base,
                       input bit cont, input int max_n, input bit poke_start);
        int  acks = 0;
        int  cyc  = 0;
        bit  fin  = 0;
        model(bnd, lim, max_n);
        exp_bytes.delete();
        exp_addr = base;
        load_program();
        @(negedge clk);
        bnd_addr  = PTR_W'(bnd);
        rpt_limit = CNT_W'(lim);
        wr_base   = base;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        while (!fin) begin
            @(negedge clk);
            cyc++;
            if (mem_we) begin
                if (exp_bytes.size() == 0) begin
                    chk(0, "R9", "write with none pending", mem_addr, 0);
                end else begin
                    logic [7:0] b;
                    b = exp_bytes.pop_front();
                    chk(mem_wdata == b, "R4", "byte value", mem_wdata, b);
                    chk(mem_addr == exp_addr, "R9", "byte address", mem_addr, exp_addr);
                    exp_addr = exp_addr + 1'b1;
                end
            end
            if (done) begin
                chk(!busy, "R7", "busy with done", busy, 0);
                fin = 1;
            end
            start = poke_start && busy && (($urandom % 8) == 0);
            if (acks < max_n) begin
                adc0_valid = ($urandom % 3) != 0;
                adc1_valid = ($urandom % 3) != 0;
            end else begin
                adc0_valid = 1'b0;
                adc1_valid = 1'b0;
            end
            adc0_data      = 16'($urandom);
            adc0_diff_data = 16'($urandom);
            adc1_data      = 16'($urandom);
            #1;
            if (adc_ack) begin
                if (exp_sel.size() == 0) begin
                    chk(0, "R3", "handshake not expected", 1, 0);
                end else begin
                    logic [2:0] s;
                    bit ok;
                    s = exp_sel.pop_front();
                    ok = (!s[0] || adc0_valid) && (!s[1] || adc0_valid) && (!s[2] || adc1_valid);
                    chk(ok, "R3", "handshake with valid low", {adc1_valid, adc0_valid}, s);
                    if (s[0]) begin exp_bytes.push_back(adc0_data[15:8]);      exp_bytes.push_back(adc0_data[7:0]); end
                    if (s[1]) begin exp_bytes.push_back(adc0_diff_data[15:8]); exp_bytes.push_back(adc0_diff_data[7:0]); end
                    if (s[2]) begin exp_bytes.push_back(adc1_data[15:8]);      exp_bytes.push_back(adc1_data[7:0]); end
                    acks++;
                end
            end
            if (cont && acks >= max_n && exp_bytes.size() == 0) fin = 1;
            if (cyc > 6000) begin
                chk(0, "R5", "run did not finish", cyc, 6000);
                fin = 1;
            end
        end
        start      = 1'b0;
        adc0_valid = 1'b0;
        adc1_valid = 1'b0;
        if (!cont) begin
            chk(exp_sel.size() == 0, "R5", "handshakes missing", exp_sel.size(), 0);
            chk(exp_bytes.size() == 0, "R4", "bytes missing", exp_bytes.size(), 0);
            @(negedge clk);
            chk(done == 1'b0, "R7", "done width", done, 0);
            begin
                bit quiet = 1;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    if (mem_we || busy) quiet = 0;
                end
                chk(quiet, "R7", "activity after halt", !quiet, 0);
            end
        end else begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b1, "R8", "busy in continuous loop", busy, 1);
            chk(done == 1'b0, "R8", "done in continuous loop", done, 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_we && !adc_ack, "R1", "outputs in reset",
            {busy, done, mem_we, adc_ack}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_we && !adc_ack, "R1", "outputs after reset",
            {busy, done, mem_we, adc_ack}, 0);
    endtask

    initial begin
        void'($urandom(32'h0005_EED1));
        rst = 1'b1; start = 1'b0; bnd_addr = '0; rpt_limit = '0; wr_base = '0;
        prog_we = 1'b0; prog_addr = '0; prog_data = '0;
        adc0_valid = 1'b0; adc1_valid = 1'b0;
        adc0_data = '0; adc0_diff_data = '0; adc1_data = '0;
        do_reset();

        // R6 R5 R10 R4: wrap across 0x3F, repeat two, no-op, halt
        clear_program();
        prog[62] = 8'h10; prog[63] = 8'h70; prog[0] = 8'h00; prog[1] = 8'h01;
        run(62, 2, 16'h1000, 0, 1000, 0);

        // R5 R4: limit zero runs once; bit 7 ignored on a capture instruction
        clear_program();
        prog[10] = 8'hD0; prog[11] = 8'h2E; prog[12] = 8'h01;
        run(10, 0, 16'hFFFC, 0, 1000, 0);

        // R8 R9: continuous loop keeps counting addresses
        clear_program();
        prog[5] = 8'h20; prog[6] = 8'h81;
        run(5, 1, 16'h0200, 1, 5, 0);
        do_reset();

        // R2: start pulses while busy, then random programs
        for (int t = 0; t < 24; t++) begin
            int len = 1 + ($urandom % 6);
            int bnd = $urandom % DEPTH;
            clear_program();
            for (int i = 0; i < len; i++)
                prog[(bnd + i) % DEPTH] = 8'($urandom) & 8'hFE;
            prog[(bnd + len) % DEPTH] = 8'h01 | (8'($urandom) & 8'h7E);
            run(bnd, $urandom % 4, 16'($urandom), 0, 1000, 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        failures++;
        $display("FAIL R7 watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule